// File: doc/BRIEF.md
# Pipelined Debug Register Scan Chain

This block is a 40-bit test-access data chain. Through it a debugger reads and writes a small bank of hardware debug registers: sixteen breakpoint value/control pairs, sixteen watchpoint value/control pairs and one vector-catch word. The TAP state machine and the chain selection sit outside the block. They drive it through three strobes, sampled on the rising edge of `tck`: capture, shift and update.

Access is pipelined by one scan. Each scan carries a new request: a write flag, 32 data bits and a 7-bit address. The same scan returns the outcome of the request before it. The request is carried out on the update strobe. A busy counter then keeps the ready flag low for a fixed number of clocks. A request that was shifted in while the captured ready flag read 0 is dropped, and the host sends it again. To collect the result of the last real request, the host ends a burst with a dummy scan to address 0.

The low bit of each control register enables that breakpoint or watchpoint, and both enable vectors and the vector-catch word leave the block as outputs. The asynchronous reset `trst_n` takes effect at once. Its release is synchronised to `tck` and completes on the second rising edge after `trst_n` goes high.

Top module: `dbg_reg_scan_chain`

## Requirements
- R1: The chain is 40 bits and shifts out least significant bit first on `tdo` while `tdi` enters at the top. Bit 0 is the write flag (1 = write, 0 = read) on the way in and the ready flag on the way out. Bits 32..1 hold the data and bits 39..33 hold the address.
- R2: On capture, bit 0 reads 1 only when the bank is idle. After a request has been carried out, ready stays 0 for BUSY_CYCLES clocks (default 3).
- R3: On update, a request is ignored if the ready flag seen at the last capture was 0, or if no capture came after the previous update. An ignored request changes no register and leaves the captured address and data as they were.
- R4: Each capture returns in bits 39..33 the address of the last request that was carried out.
- R5: Each capture returns in bits 32..1 the register contents if that request was a read, or the written value if it was a write.
- R6: Address map: vector catch at 7, breakpoint value n at 64+n, breakpoint control n at 80+n, watchpoint value n at 96+n, watchpoint control n at 112+n (n = 0..15).
- R7: Address 0 and every other unmapped address read as zero, and writes to them change nothing.
- R8: `bp_enable[n]` and `wp_enable[n]` are bit 0 of the matching control register, so writing zero turns that unit off. `vcatch` mirrors the vector-catch register, so writing zero clears every catch.
- R9: Reset clears all registers and the captured address and data. The first capture after reset returns 40'h1.
- R10: The outputs `bp_enable`, `wp_enable` and `vcatch` change only on an update strobe that carries out a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| capture_dr | input | 1 | Load the result word into the chain |
| shift_dr | input | 1 | Shift the chain by one bit |
| update_dr | input | 1 | Carry out the shifted-in request |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| bp_enable | output | 16 | Breakpoint enables (control bit 0) |
| wp_enable | output | 16 | Watchpoint enables (control bit 0) |
| vcatch | output | 32 | Vector-catch register contents |

## Verification
The assertions check the following on every clock:
- A dropped request leaves all outputs unchanged.
- The outputs never move without an update.
- A request that is carried out makes ready fall on the next clock.
- The ready bit captured into the chain appears on `tdo` one clock after capture.

Only the bench scenarios can show the rest: the one-scan pipelining of addresses and data, the address map, readback of values, unmapped addresses reading zero, and the effect of reset in the middle of a run. The bench reference model checks these against every captured word and against the outputs on every clock.

// File: rtl/dbgsc_pkg.sv
package dbgsc_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 32;
  localparam int CHAIN_W = 1 + DATA_W + ADDR_W;

  localparam int VCR_ADDR = 7;
  localparam int BVR_BASE = 64;
  localparam int BCR_BASE = 80;
  localparam int WVR_BASE = 96;
  localparam int WCR_BASE = 112;

  // chain layout: address at the top, write/ready flag at bit 0
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              wr;
  } dbgsc_req_t;
endpackage

// File: rtl/dbgsc_shift.sv
module dbgsc_shift
  import dbgsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               shift,
  input  logic               tdi,
  input  logic [CHAIN_W-1:0] cap_word,
  output logic [CHAIN_W-1:0] sr_q,
  output logic               tdo
);
  logic [CHAIN_W-1:0] sr_d;
  logic               sr_en;

  assign sr_en = capture | shift;

  always_comb begin
    sr_d = sr_q;
    if (capture)    sr_d = cap_word;
    else if (shift) sr_d = {tdi, sr_q[CHAIN_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign tdo = sr_q[0];
endmodule

// File: rtl/dbgsc_busy.sv
module dbgsc_busy #(
  parameter int BUSY_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  generate
    if (BUSY_CYCLES == 0) begin : g_nobusy
      assign ready = 1'b1;
    end else begin : g_cnt
      localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      assign cnt_en = start | (cnt_q != '0);

      always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign ready = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/dbgsc_unit.sv
module dbgsc_unit
  import dbgsc_pkg::*;
#(
  parameter int VAL_ADDR = 64,
  parameter int CTL_ADDR = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] val_q,
  output logic [DATA_W-1:0] ctl_q
);
  logic val_en, ctl_en;

  assign val_en = we && (addr == ADDR_W'(VAL_ADDR));
  assign ctl_en = we && (addr == ADDR_W'(CTL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= wdata;
  end
endmodule

// File: rtl/dbgsc_bank.sv
module dbgsc_bank
  import dbgsc_pkg::*;
#(
  parameter int NUM_BP = 16,
  parameter int NUM_WP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_BP-1:0] bp_en,
  output logic [NUM_WP-1:0] wp_en,
  output logic [DATA_W-1:0] vcatch
);
  logic [DATA_W-1:0] bp_val [NUM_BP];
  logic [DATA_W-1:0] bp_ctl [NUM_BP];
  logic [DATA_W-1:0] wp_val [NUM_WP];
  logic [DATA_W-1:0] wp_ctl [NUM_WP];
  logic [DATA_W-1:0] vcr_q;
  logic              vcr_en;

  generate
    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
      dbgsc_unit #(.VAL_ADDR(BVR_BASE + g), .CTL_ADDR(BCR_BASE + g)) u_unit (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .val_q(bp_val[g]), .ctl_q(bp_ctl[g]));
      assign bp_en[g] = bp_ctl[g][0];
    end
    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
      dbgsc_unit #(.VAL_ADDR(WVR_BASE + g), .CTL_ADDR(WCR_BASE + g)) u_unit (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .val_q(wp_val[g]), .ctl_q(wp_ctl[g]));
      assign wp_en[g] = wp_ctl[g][0];
    end
  endgenerate

  assign vcr_en = we && (addr == ADDR_W'(VCR_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vcr_q <= '0;
    else if (vcr_en) vcr_q <= wdata;
  end

  assign vcatch = vcr_q;

  // read mux; unmapped addresses fall through to zero
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(VCR_ADDR)) rdata = vcr_q;
    for (int i = 0; i < NUM_BP; i++) begin
      if (addr == ADDR_W'(BVR_BASE + i)) rdata = bp_val[i];
      if (addr == ADDR_W'(BCR_BASE + i)) rdata = bp_ctl[i];
    end
    for (int i = 0; i < NUM_WP; i++) begin
      if (addr == ADDR_W'(WVR_BASE + i)) rdata = wp_val[i];
      if (addr == ADDR_W'(WCR_BASE + i)) rdata = wp_ctl[i];
    end
  end
endmodule

// File: rtl/dbg_reg_scan_chain.sv
module dbg_reg_scan_chain
  import dbgsc_pkg::*;
#(
  parameter int NUM_BP      = 16,
  parameter int NUM_WP      = 16,
  parameter int BUSY_CYCLES = 3
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic [NUM_BP-1:0] bp_enable,
  output logic [NUM_WP-1:0] wp_enable,
  output logic [DATA_W-1:0] vcatch
);
  logic [1:0]         rst_sync_q;
  logic               rst_n;
  logic [CHAIN_W-1:0] sr_q;
  logic [CHAIN_W-1:0] cap_word;
  dbgsc_req_t         req;
  logic               rdy;
  logic               do_req;
  logic [DATA_W-1:0]  rdata;
  logic               cap_rdy_q, cap_rdy_d, cap_rdy_en;
  logic [ADDR_W-1:0]  cap_addr_q, cap_addr_d;
  logic [DATA_W-1:0]  cap_data_q, cap_data_d;

  // asynchronous assertion, release after two tck edges
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign cap_word = {cap_addr_q, cap_data_q, rdy};

  dbgsc_shift u_shift (
    .clk(tck), .rst_n(rst_n), .capture(capture_dr), .shift(shift_dr),
    .tdi(tdi), .cap_word(cap_word), .sr_q(sr_q), .tdo(tdo));

  assign req    = sr_q;
  assign do_req = update_dr && cap_rdy_q;

  dbgsc_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(tck), .rst_n(rst_n), .start(do_req), .ready(rdy));

  dbgsc_bank #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_bank (
    .clk(tck), .rst_n(rst_n), .we(do_req && req.wr), .addr(req.addr),
    .wdata(req.data), .rdata(rdata), .bp_en(bp_enable), .wp_en(wp_enable),
    .vcatch(vcatch));

  // ready seen at capture gates the following update
  assign cap_rdy_en = capture_dr | update_dr;
  always_comb begin
    cap_rdy_d = cap_rdy_q;
    if (capture_dr)     cap_rdy_d = rdy;
    else if (update_dr) cap_rdy_d = 1'b0;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          cap_rdy_q <= 1'b0;
    else if (cap_rdy_en) cap_rdy_q <= cap_rdy_d;
  end

  // result of the performed request, returned by the next capture
  always_comb begin
    cap_addr_d = req.addr;
    cap_data_d = req.wr ? req.data : rdata;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else if (do_req) begin
      cap_addr_q <= cap_addr_d;
      cap_data_q <= cap_data_d;
    end
  end
endmodule

module dbgsc_checker #(
  parameter int NUM_BP      = 16,
  parameter int NUM_WP      = 16,
  parameter int BUSY_CYCLES = 3
) (
  input logic              tck,
  input logic              rst_n,
  input logic              capture_dr,
  input logic              shift_dr,
  input logic              update_dr,
  input logic              tdo,
  input logic [NUM_BP-1:0] bp_enable,
  input logic [NUM_WP-1:0] wp_enable,
  input logic [31:0]       vcatch,
  input logic              cap_rdy,
  input logic              rdy
);
  // R1
  strobe_exclusive_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({capture_dr, shift_dr, update_dr}));

  // R1
  ready_on_tdo_chk: assert property (@(posedge tck) disable iff (!rst_n)
    capture_dr |=> (tdo == $past(rdy)));

  // R3
  ignored_req_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (update_dr && !cap_rdy) |=> ($stable(bp_enable) && $stable(wp_enable) && $stable(vcatch)));

  // R10
  no_update_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !update_dr |=> ($stable(bp_enable) && $stable(wp_enable) && $stable(vcatch)));

  generate
    if (BUSY_CYCLES > 0) begin : g_busy_chk
      // R2
      busy_after_req_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (update_dr && cap_rdy) |=> !rdy);
    end
  endgenerate
endmodule

bind dbg_reg_scan_chain dbgsc_checker #(
  .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .update_dr(update_dr), .tdo(tdo), .bp_enable(bp_enable),
  .wp_enable(wp_enable), .vcatch(vcatch), .cap_rdy(cap_rdy_q), .rdy(rdy));

// File: tb/dbg_reg_scan_chain_bench.sv
`timescale 1ns/1ps
module dbg_reg_scan_chain_bench;
  localparam int BUSY = 3;

  logic        tck = 1'b0;
  logic        trst_n, capture_dr, shift_dr, update_dr, tdi;
  logic        tdo;
  logic [15:0] bp_enable, wp_enable;
  logic [31:0] vcatch;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  bit started = 0;

  always #4 tck = ~tck;

  dbg_reg_scan_chain #(.NUM_BP(16), .NUM_WP(16), .BUSY_CYCLES(BUSY)) u_dbg_reg_scan_chain (
    .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .bp_enable(bp_enable),
    .wp_enable(wp_enable), .vcatch(vcatch));

  // behavioural reference model
  logic [31:0] m_bv [16];
  logic [31:0] m_bc [16];
  logic [31:0] m_wv [16];
  logic [31:0] m_wc [16];
  logic [31:0] m_vc;
  logic [6:0]  m_addr;
  logic [31:0] m_data;
  int          m_busy;
  bit          m_caprdy;
  logic [39:0] m_exp;
  bit          q_wr;
  logic [6:0]  q_addr;
  logic [31:0] q_data;

  function automatic logic [31:0] m_read(int a);
    if (a == 7) return m_vc;
    if (a >= 64 && a < 80) return m_bv[a-64];
    if (a >= 80 && a < 96) return m_bc[a-80];
    if (a >= 96 && a < 112) return m_wv[a-96];
    if (a >= 112 && a < 128) return m_wc[a-112];
    return 32'h0;
  endfunction

  task automatic m_write(int a, logic [31:0] d);
    if (a == 7) m_vc = d;
    else if (a >= 64 && a < 80) m_bv[a-64] = d;
    else if (a >= 80 && a < 96) m_bc[a-80] = d;
    else if (a >= 96 && a < 112) m_wv[a-96] = d;
    else if (a >= 112 && a < 128) m_wc[a-112] = d;
  endtask

  always @(posedge tck) begin
    if (!trst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_bv[i] = 0; m_bc[i] = 0; m_wv[i] = 0; m_wc[i] = 0;
      end
      m_vc = 0; m_addr = 0; m_data = 0; m_busy = 0; m_caprdy = 0;
    end else begin
      if (capture_dr) begin
        m_exp    = {m_addr, m_data, (m_busy == 0)};
        m_caprdy = (m_busy == 0);
      end
      if (update_dr && m_caprdy) begin
        m_data = q_wr ? q_data : m_read(int'(q_addr));
        m_addr = q_addr;
        if (q_wr) m_write(int'(q_addr), q_data);
        m_busy = BUSY;
      end else if (m_busy > 0) begin
        m_busy--;
      end
      if (update_dr) m_caprdy = 0;
    end
  end

  task automatic chk(bit ok, string req, logic [39:0] act, logic [39:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // outputs against the model on every clock
  always @(negedge tck) begin
    if (started && !done) begin
      logic [15:0] eb, ew;
      for (int i = 0; i < 16; i++) begin
        eb[i] = m_bc[i][0];
        ew[i] = m_wc[i][0];
      end
      chk(bp_enable == eb, "R8/R10 bp_enable", {24'h0, bp_enable}, {24'h0, eb});
      chk(wp_enable == ew, "R8/R10 wp_enable", {24'h0, wp_enable}, {24'h0, ew});
      chk(vcatch == m_vc, "R8/R10 vcatch", {8'h0, vcatch}, {8'h0, m_vc});
    end
  end

  // one full scan; called and returns at a falling edge
  task automatic scan(input bit wr, input logic [6:0] a, input logic [31:0] d,
                      input int gap, output logic [39:0] got);
    logic [39:0] rq;
    rq = {a, d, wr};
    q_wr = wr; q_addr = a; q_data = d;
    capture_dr = 1'b1;
    @(negedge tck);
    capture_dr = 1'b0;
    shift_dr   = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tdi    = rq[i];
      got[i] = tdo;
      @(negedge tck);
    end
    shift_dr  = 1'b0;
    update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
    repeat (gap) @(negedge tck);
    chk(got == m_exp, "R1 R4 R5 captured word", got, m_exp);
  endtask

  task automatic do_reset();
    trst_n = 1'b0;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    repeat (4) @(negedge tck);
  endtask

  initial begin
    logic [39:0] g;
    capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    q_wr = 0; q_addr = 0; q_data = 0;
    @(negedge tck);
    do_reset();
    started = 1;

    // R9: first capture after reset
    scan(1'b0, 7'h00, 32'h0, 4, g);
    chk(g == 40'h1, "R9 reset capture", g, 40'h1);

    // R6: write breakpoint value 3 then control 3
    scan(1'b1, 7'h43, 32'hCAFE0001, 4, g);
    chk(g[39:33] == 7'h00, "R4 nop address", {33'h0, g[39:33]}, 40'h0);
    scan(1'b1, 7'h53, 32'h1, 4, g);
    chk(g[0] == 1'b1, "R1 R2 ready bit", {39'h0, g[0]}, 40'h1);
    chk(g[39:33] == 7'h43, "R4 previous address", {33'h0, g[39:33]}, 40'h43);
    chk(g[32:1] == 32'hCAFE0001, "R5 written value", {8'h0, g[32:1]}, 40'hCAFE0001);
    chk(bp_enable == 16'h0008, "R6 R8 bp3 enabled", {24'h0, bp_enable}, 40'h8);

    // R5: read back, then a dummy scan collects the data
    scan(1'b0, 7'h43, 32'h0, 4, g);
    scan(1'b0, 7'h00, 32'h0, 4, g);
    chk(g[32:1] == 32'hCAFE0001, "R5 read contents", {8'h0, g[32:1]}, 40'hCAFE0001);

    // R6: watchpoint control 5, watchpoint value 2, breakpoint value 15, vector catch
    scan(1'b1, 7'h75, 32'h1, 4, g);
    chk(wp_enable == 16'h0020, "R6 wp5 enabled", {24'h0, wp_enable}, 40'h20);
    scan(1'b1, 7'h62, 32'h12345678, 4, g);
    scan(1'b1, 7'h4F, 32'h0BADF00D, 4, g);
    scan(1'b1, 7'h07, 32'h000000FF, 4, g);
    chk(vcatch == 32'hFF, "R6 vector catch", {8'h0, vcatch}, 40'hFF);
    scan(1'b0, 7'h62, 32'h0, 4, g);
    scan(1'b0, 7'h4F, 32'h0, 4, g);
    chk(g[32:1] == 32'h12345678, "R6 wvr2 read", {8'h0, g[32:1]}, 40'h12345678);
    scan(1'b0, 7'h00, 32'h0, 4, g);
    chk(g[32:1] == 32'h0BADF00D, "R6 bvr15 read", {8'h0, g[32:1]}, 40'h0BADF00D);

    // R7: unmapped read and write
    scan(1'b1, 7'h21, 32'hDEADBEEF, 4, g);
    scan(1'b0, 7'h21, 32'h0, 4, g);
    scan(1'b0, 7'h00, 32'h0, 4, g);
    chk(g[32:1] == 32'h0, "R7 unmapped reads zero", {8'h0, g[32:1]}, 40'h0);
    chk(g[39:33] == 7'h21, "R7 unmapped address", {33'h0, g[39:33]}, 40'h21);

    // R2 R3: back-to-back scan with no idle time
    scan(1'b1, 7'h51, 32'h1, 0, g);
    scan(1'b1, 7'h52, 32'h1, 4, g);
    chk(g[0] == 1'b0, "R2 busy ready low", {39'h0, g[0]}, 40'h0);
    chk(bp_enable == 16'h000A, "R3 ignored write", {24'h0, bp_enable}, 40'hA);
    scan(1'b0, 7'h00, 32'h0, 4, g);
    chk(g[39:33] == 7'h51, "R3 capture kept", {33'h0, g[39:33]}, 40'h51);

    // R8: zero writes disable units and clear vector catch
    scan(1'b1, 7'h53, 32'h0, 4, g);
    chk(bp_enable == 16'h0002, "R8 bp3 disabled", {24'h0, bp_enable}, 40'h2);
    scan(1'b1, 7'h75, 32'h0, 4, g);
    chk(wp_enable == 16'h0000, "R8 wp5 disabled", {24'h0, wp_enable}, 40'h0);
    scan(1'b1, 7'h07, 32'h0, 4, g);
    chk(vcatch == 32'h0, "R8 vector catch cleared", {8'h0, vcatch}, 40'h0);

    // R9: reset in the middle of a run
    do_reset();
    chk(bp_enable == 16'h0, "R9 enables cleared", {24'h0, bp_enable}, 40'h0);
    scan(1'b0, 7'h00, 32'h0, 4, g);
    chk(g == 40'h1, "R9 capture after reset", g, 40'h1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R9 watchdog expired act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule